// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps four 16-bit segment base registers (code, stack, data, extra) and turns a 16-bit offset into a 20-bit physical address. Each request carries an access class; the class selects which base register applies. The chosen base is moved up by four bit positions and added to the offset. Any result past 20 bits wraps around inside the one-megabyte space, so a single segment covers at most 64 KB.

The segment registers are loaded through a synchronous write port and can be read back combinationally by index. A request may name a segment directly through an override input. In that case the override takes the place of the selection by class. The address and a valid strobe are presented from registers one cycle after the request. A register write in the same cycle as a request does not affect that request.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, all four segment registers read 0, and `addr_vld` is 0 with `addr_out` equal to 0.
- R2: When `req_vld` is high at a clock edge, `addr_vld` is high during the next cycle. When `req_vld` is low, `addr_vld` is low during the next cycle.
- R3: The physical address equals (segment << 4) + offset, taken modulo 2^20. For example, segment 0x456A with offset 0x1620 gives 0x46CC0.
- R4: Access class code 0 (instruction fetch) uses the code segment, index 0.
- R5: Access class code 1 (stack access via stack or base pointer) uses the stack segment, index 1.
- R6: Access class code 2 (data operand via index registers) uses the data segment, index 2.
- R7: Access class code 3 (string destination) uses the extra segment, index 3.
- R8: When `ovr_en` is high, the segment selected by `ovr_sel` is used and the access class is ignored.
- R9: A write with `wr_en` high loads `wr_data` into the segment at index `wr_sel` (0 code, 1 stack, 2 data, 3 extra). The other three segments are unchanged.
- R10: A request in the same cycle as a write to its segment uses the value that segment held before the write.
- R11: `rd_data` always shows the current value of the segment at index `rd_sel`.
- R12: When `req_vld` is low, `addr_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 2 | Segment index to write |
| wr_data | input | 16 | Value to write |
| rd_sel | input | 2 | Segment index to read back |
| rd_data | output | 16 | Readback value |
| req_vld | input | 1 | Address request strobe |
| req_kind | input | 2 | Access class of the request |
| req_off | input | 16 | Offset within the segment |
| ovr_en | input | 1 | Use ovr_sel instead of the access class |
| ovr_sel | input | 2 | Override segment index |
| addr_vld | output | 1 | Registered address valid |
| addr_out | output | 20 | Registered physical address |

## Verification
Checked on every cycle by assertions:
- The strobe follows the request by exactly one cycle.
- The address holds while no request is made.
- The address is the wrapped sum of the selected segment's previous value and the previous offset.
- A write reaches only its target register.

Shown only by the bench scenarios:
- The mapping from access class to register.
- The override path.
- Wraparound at the top of the megabyte.
- Use of the old segment value when a write and a request coincide.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int SHIFT  = 4;
  localparam int ADDR_W = SEG_W + SHIFT;
  localparam int NSEG   = 4;
  localparam int SEL_W  = $clog2(NSEG);

  typedef enum logic [SEL_W-1:0] {
    SEG_CODE  = 2'd0,
    SEG_STACK = 2'd1,
    SEG_DATA  = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_idx_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_STACK = 2'd1,
    ACC_DATA  = 2'd2,
    ACC_SDST  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int W = SEG_W,
  parameter int N = NSEG,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic [SW-1:0] rd_sel,
  output logic [W-1:0]  rd_data,
  input  logic [SW-1:0] lk_sel,
  output logic [W-1:0]  lk_data
);
  logic [W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst) regs[i] <= '0;
      else if (wr_en && wr_sel == SW'(i)) regs[i] <= wr_data;
    end

    assert_write_isolated_R9: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_sel == SW'(i)) |=> $stable(regs[i]));
  end

  assign rd_data = regs[rd_sel];
  assign lk_data = regs[lk_sel];
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int SW = SEL_W
) (
  input  logic [1:0]    kind,
  input  logic          ovr_en,
  input  logic [SW-1:0] ovr_sel,
  output logic [SW-1:0] sel
);
  always_comb begin
    if (ovr_en) sel = ovr_sel;
    else begin
      unique case (acc_kind_e'(kind))
        ACC_FETCH: sel = SW'(SEG_CODE);
        ACC_STACK: sel = SW'(SEG_STACK);
        ACC_DATA:  sel = SW'(SEG_DATA);
        ACC_SDST:  sel = SW'(SEG_EXTRA);
        default:   sel = SW'(SEG_CODE);
      endcase
    end
  end
endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
  parameter int SW = 16,
  parameter int OW = 16,
  parameter int SH = 4,
  localparam int AW = SW + SH
) (
  input  logic [SW-1:0] seg,
  input  logic [OW-1:0] off,
  output logic [AW-1:0] phys
);
  logic [AW:0] full;
  assign full = {1'b0, seg, {SH{1'b0}}} + (AW+1)'(off);
  assign phys = full[AW-1:0];
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEGW = SEG_W,
  parameter int OFFW = OFF_W,
  parameter int SHW  = SHIFT,
  localparam int AW  = SEGW + SHW,
  localparam int SW  = SEL_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SW-1:0]   wr_sel,
  input  logic [SEGW-1:0] wr_data,
  input  logic [SW-1:0]   rd_sel,
  output logic [SEGW-1:0] rd_data,
  input  logic            req_vld,
  input  logic [1:0]      req_kind,
  input  logic [OFFW-1:0] req_off,
  input  logic            ovr_en,
  input  logic [SW-1:0]   ovr_sel,
  output logic            addr_vld,
  output logic [AW-1:0]   addr_out
);
  logic [SW-1:0]   sel;
  logic [SEGW-1:0] seg_val;
  logic [AW-1:0]   phys;

  seg_select #(.SW(SW)) u_sel (
    .kind(req_kind), .ovr_en(ovr_en), .ovr_sel(ovr_sel), .sel(sel)
  );

  seg_regfile #(.W(SEGW), .N(NSEG)) u_rf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .lk_sel(sel), .lk_data(seg_val)
  );

  addr_adder #(.SW(SEGW), .OW(OFFW), .SH(SHW)) u_add (
    .seg(seg_val), .off(req_off), .phys(phys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_vld <= 1'b0;
      addr_out <= '0;
    end else begin
      addr_vld <= req_vld;
      if (req_vld) addr_out <= phys;
    end
  end

  assert_vld_follows_R2: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> addr_vld);
  assert_vld_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !addr_vld);
  assert_addr_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> $stable(addr_out));
  assert_addr_sum_R3: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> addr_out == AW'({$past(seg_val), {SHW{1'b0}}} + AW'($past(req_off))));
  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!addr_vld && addr_out == '0));
endmodule

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
  logic clk = 0, rst = 1;
  logic wr_en = 0; logic [1:0] wr_sel = 0; logic [15:0] wr_data = 0;
  logic [1:0] rd_sel = 0; logic [15:0] rd_data;
  logic req_vld = 0; logic [1:0] req_kind = 0; logic [15:0] req_off = 0;
  logic ovr_en = 0; logic [1:0] ovr_sel = 0;
  logic addr_vld; logic [19:0] addr_out;
  int n_chk = 0, n_fail = 0;
  logic [15:0] model [4];

  always #10 clk = ~clk;

  seg_addr_gen dut (.*);

  function automatic logic [19:0] phys_of(logic [15:0] s, logic [15:0] o);
    return 20'({s, 4'h0} + {4'h0, o});
  endfunction

  function automatic logic [1:0] seg_for(logic [1:0] k, logic oe, logic [1:0] os);
    return oe ? os : k;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [15:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(posedge clk); #1; wr_en = 0; model[s] = d;
  endtask

  task automatic req(string tag, logic [1:0] k, logic [15:0] o, logic oe, logic [1:0] os);
    logic [19:0] e;
    e = phys_of(model[seg_for(k, oe, os)], o);
    req_vld = 1; req_kind = k; req_off = o; ovr_en = oe; ovr_sel = os;
    @(posedge clk); #1; req_vld = 0; ovr_en = 0;
    check({tag, " vld"}, 32'(addr_vld), 32'd1);
    check(tag, 32'(addr_out), 32'(e));
  endtask

  initial begin
    #2000000; n_fail++; $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1); $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) model[i] = 0;
    repeat (2) @(posedge clk); #1; rst = 0;
    check("R1 vld", 32'(addr_vld), 0); check("R1 addr", 32'(addr_out), 0);
    for (int i = 0; i < 4; i++) begin rd_sel = 2'(i); #1; check("R1 rd", 32'(rd_data), 0); end

    wr(0, 16'h456A); wr(1, 16'h2000); wr(2, 16'h3000); wr(3, 16'hF000);
    for (int i = 0; i < 4; i++) begin rd_sel = 2'(i); #1; check("R11 R9 rd", 32'(rd_data), 32'(model[i])); end
    req("R3 R4 example", 2'd0, 16'h1620, 0, 0);
    check("R3 literal", 32'(addr_out), 32'h46CC0);
    req("R5 stack", 2'd1, 16'h0010, 0, 0);
    req("R6 data", 2'd2, 16'h0020, 0, 0);
    req("R7 extra", 2'd3, 16'hFFFF, 0, 0);
    wr(3, 16'hFFFF);
    req("R3 wrap", 2'd3, 16'h0020, 0, 0);
    check("R3 wrap literal", 32'(addr_out), 32'h00010);
    req("R8 override", 2'd0, 16'h0001, 1, 2'd2);
    check("R8 literal", 32'(addr_out), 32'h30001);

    // R12 and R2: idle keeps address, drops valid
    @(posedge clk); #1;
    check("R2 idle", 32'(addr_vld), 0); check("R12 hold", 32'(addr_out), 32'h30001);

    // R10: write and request together
    wr_en = 1; wr_sel = 0; wr_data = 16'h1111;
    req_vld = 1; req_kind = 0; req_off = 16'h0005;
    @(posedge clk); #1; wr_en = 0; req_vld = 0;
    check("R10 old seg", 32'(addr_out), 32'(phys_of(16'h456A, 16'h0005)));
    model[0] = 16'h1111;
    rd_sel = 0; #1; check("R10 R9 new", 32'(rd_data), 32'h1111);

    for (int i = 0; i < 200; i++) begin
      if ($urandom % 4 == 0) wr(2'($urandom), 16'($urandom));
      req("R3 R8 random", 2'($urandom), 16'($urandom), 1'($urandom), 2'($urandom));
    end
    for (int i = 0; i < 4; i++) begin rd_sel = 2'(i); #1; check("R9 R11 final", 32'(rd_data), 32'(model[i])); end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule